// File: doc/BRIEF.md
# Banked UART Register Access Decoder

This block is the processor-facing register file of a 16550-style serial port that has been widened with extra register banks. A host drives a three-bit register index, a select, separate read and write strokes and a byte of data. The block works out which register an access means from three things: the value currently held in the line-control register, a gate bit in the enhanced-function register, and an alias bit in the feature-control register. It then reads or writes that register.

The divisor bytes, the fractional divisor, the line, modem and interrupt-enable controls, the enhanced and feature controls, the scratch byte, the mode-select byte, the receive/transmit mode nibble and the four flow-control characters are all stored here. Their live values are driven out to the rest of the port. Receive data, the FIFO fill count, the interrupt status, the line status and the modem status are supplied from outside. The block reports reads of those sources, pushes of transmit data and writes of FIFO control as one-cycle strobes, so that the FIFOs and status logic can pop data or clear flags.

Top module: `uart_regbank_decoder`

## Requirements
- R1: With line-control bit 7 at 0, reading index 0 returns `rx_data_i` and raises `rx_pop_o`. Writing index 0 raises `tx_push_o` and places the byte on `strobe_data_o`. Index 1 is the interrupt-enable register.
- R2: With line-control bit 7 at 1 and line control not equal to 0xBF, index 0 is the divisor low byte and index 1 is the divisor high byte. Neither raises any strobe.
- R3: Index 2 is the fractional divisor register only when line-control bit 7 is 1, line control is not 0xBF and enhanced-function bit 4 is 1. In every other non-0xBF case, index 2 reads `isr_i` and raises `isr_rd_o`, and a write there raises `fcr_wr_o` with the byte on `strobe_data_o`.
- R4: With line control equal to 0xBF, the enhanced bank is mapped:
  - Index 0 reads `fifo_level_i` and ignores writes.
  - Index 1 is feature control and index 2 is enhanced function.
  - Indices 4, 5, 6 and 7 hold flow characters one to four. These appear on `flow_chars_o` at bits [7:0], [15:8], [23:16] and [31:24].
- R5: Outside the 0xBF bank, index 7 depends on feature-control bit 6. When that bit is 0, index 7 is the scratch register. When it is 1, index 7 writes the mode-select register (`emsr_o`) and reads `fifo_level_i`.
- R6: Outside the 0xBF bank, reading index 6 returns `msr_i` and raises `msr_rd_o`. A write to index 6 loads data bits [7:4] into `mode_o[3:0]`, but only while enhanced-function bit 4 is 1. Those bits are fast-IR, 9-bit, receive-disable and transmit-disable, from MSB to LSB.
- R7: While enhanced-function bit 4 is 0:
  - Interrupt-enable bits [7:4] and modem-control bits [7:5] keep their stored value on a write.
  - Those bits read as 0, on the bus and on `ier_o`/`mcr_o`.
- R8: Index 3 is line control in every bank. Outside the 0xBF bank, index 5 reads `lsr_i` and raises `lsr_rd_o`, and a write there is ignored.
- R9: Each access raises at most one strobe. The strobe is high in exactly the one cycle that follows the access edge. Read data appears combinationally in the access cycle.
- R10: Reset sets line control to 0x03 and clears all other stored registers and all strobes.
- R11: Writes to read-only places leave every exported register and every strobe unchanged. These places are index 0 in the 0xBF bank, index 5 outside it, and index 6 while enhanced-function bit 4 is 0.
- R12: When read and write are both active in one selected cycle, only the write takes place and no read strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Register select |
| rd_i | input | 1 | Read stroke, one access per cycle |
| wr_i | input | 1 | Write stroke, one access per cycle |
| addr_i | input | 3 | Register index |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 0 when no read is active |
| rx_data_i | input | 8 | Head of receive FIFO |
| fifo_level_i | input | 8 | FIFO fill count |
| isr_i | input | 8 | Interrupt status value |
| lsr_i | input | 8 | Line status value |
| msr_i | input | 8 | Modem status value |
| rx_pop_o | output | 1 | Receive data was read |
| tx_push_o | output | 1 | Transmit byte written |
| fcr_wr_o | output | 1 | FIFO control written |
| isr_rd_o | output | 1 | Interrupt status was read |
| lsr_rd_o | output | 1 | Line status was read |
| msr_rd_o | output | 1 | Modem status was read |
| strobe_data_o | output | 8 | Byte accompanying tx_push_o / fcr_wr_o |
| lcr_o | output | 8 | Line control |
| dll_o | output | 8 | Divisor low byte |
| dlm_o | output | 8 | Divisor high byte |
| dld_o | output | 8 | Fractional divisor |
| ier_o | output | 8 | Effective interrupt enable |
| mcr_o | output | 8 | Effective modem control |
| efr_o | output | 8 | Enhanced function |
| fctr_o | output | 8 | Feature control |
| emsr_o | output | 8 | Mode select |
| mode_o | output | 4 | Fast-IR, 9-bit, RX disable, TX disable |
| flow_chars_o | output | 32 | Four flow-control characters |

## Verification
Two things can land in one cycle: a read and a write, when the host raises both strokes together on a selected index. The bench does this on index 0 of the standard bank. That index both pops receive data and pushes transmit data, so it shows which one wins. The bench expects the push strobe together with the byte, and a low pop strobe. A bank change and the access that depends on it also follow each other back to back. The sweep writes line control and then at once uses the new bank, and it judges every step against a model kept in the bench.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;

    localparam int DW = 8;
    localparam int AW = 3;
    localparam int MODE_W = 4;
    localparam int FLOW_N = 4;
    localparam int GATE_BIT = 4;
    localparam int ALIAS_BIT = 6;
    localparam logic [DW-1:0] IER_BASE_MASK = 8'h0F;
    localparam logic [DW-1:0] MCR_BASE_MASK = 8'h1F;

    typedef enum logic [1:0] {
        BANK_STD,
        BANK_DIV,
        BANK_ENH
    } bank_e;

    typedef enum logic [4:0] {
        T_NONE, T_RHR, T_THR, T_IER, T_DLL, T_DLM, T_DLD, T_ISR, T_FCR,
        T_LCR, T_MCR, T_LSR, T_MSR, T_MODE, T_SPR, T_EMSR, T_FC,
        T_FCTR, T_EFR, T_XON1, T_XON2, T_XOFF1, T_XOFF2
    } tgt_e;

    typedef struct packed {
        logic rx_pop;
        logic tx_push;
        logic fcr_wr;
        logic isr_rd;
        logic lsr_rd;
        logic msr_rd;
    } strobe_t;

    typedef struct packed {
        logic [DW-1:0]     lcr;
        logic [DW-1:0]     dll;
        logic [DW-1:0]     dlm;
        logic [DW-1:0]     dld;
        logic [DW-1:0]     ier;
        logic [DW-1:0]     mcr;
        logic [DW-1:0]     efr;
        logic [DW-1:0]     fctr;
        logic [DW-1:0]     emsr;
        logic [DW-1:0]     spr;
        logic [MODE_W-1:0] mode;
    } regs_t;

    function automatic bank_e bank_of(input logic [DW-1:0] lcr, input logic [DW-1:0] key);
        if (lcr == key)
            return BANK_ENH;
        else if (lcr[DW-1])
            return BANK_DIV;
        else
            return BANK_STD;
    endfunction

    function automatic tgt_e map_access(input bank_e bank, input logic [AW-1:0] a,
                                        input logic gate, input logic alias_on,
                                        input logic is_wr);
        tgt_e t;
        t = T_NONE;
        if (bank == BANK_ENH) begin
            case (a)
                3'd0: t = is_wr ? T_NONE : T_FC;
                3'd1: t = T_FCTR;
                3'd2: t = T_EFR;
                3'd3: t = T_LCR;
                3'd4: t = T_XON1;
                3'd5: t = T_XON2;
                3'd6: t = T_XOFF1;
                default: t = T_XOFF2;
            endcase
        end else begin
            case (a)
                3'd0: t = (bank == BANK_DIV) ? T_DLL : (is_wr ? T_THR : T_RHR);
                3'd1: t = (bank == BANK_DIV) ? T_DLM : T_IER;
                3'd2: t = (bank == BANK_DIV && gate) ? T_DLD : (is_wr ? T_FCR : T_ISR);
                3'd3: t = T_LCR;
                3'd4: t = T_MCR;
                3'd5: t = is_wr ? T_NONE : T_LSR;
                3'd6: t = is_wr ? (gate ? T_MODE : T_NONE) : T_MSR;
                default: t = alias_on ? (is_wr ? T_EMSR : T_FC) : T_SPR;
            endcase
        end
        return t;
    endfunction

    function automatic logic [DW-1:0] gated_mask(input logic gate, input logic [DW-1:0] base);
        return gate ? {DW{1'b1}} : base;
    endfunction

endpackage

// File: rtl/rb_decode.sv
module rb_decode
    import uart_rb_pkg::*;
#(
    parameter logic [DW-1:0] ENH_KEY = 8'hBF
) (
    input  logic            cs,
    input  logic            rd,
    input  logic            wr,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   lcr,
    input  logic            gate,
    input  logic            alias_on,
    output logic            rd_en,
    output logic            wr_en,
    output tgt_e            rd_tgt,
    output tgt_e            wr_tgt
);
    bank_e bank;

    always_comb begin
        wr_en  = cs && wr;
        rd_en  = cs && rd && !wr;
        bank   = bank_of(lcr, ENH_KEY);
        rd_tgt = rd_en ? map_access(bank, addr, gate, alias_on, 1'b0) : T_NONE;
        wr_tgt = wr_en ? map_access(bank, addr, gate, alias_on, 1'b1) : T_NONE;
    end
endmodule

// File: rtl/rb_regs.sv
module rb_regs
    import uart_rb_pkg::*;
#(
    parameter logic [DW-1:0] LCR_RESET = 8'h03
) (
    input  logic                   clk,
    input  logic                   rst,
    input  tgt_e                   wr_tgt,
    input  logic [DW-1:0]          wdata,
    output regs_t                  regs,
    output logic [FLOW_N*DW-1:0]   flow
);
    logic          gate;
    logic [DW-1:0] ier_keep;
    logic [DW-1:0] mcr_keep;
    logic [DW-1:0] flow_q [FLOW_N];

    assign gate     = regs.efr[GATE_BIT];
    assign ier_keep = gated_mask(gate, IER_BASE_MASK);
    assign mcr_keep = gated_mask(gate, MCR_BASE_MASK);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs     <= '0;
            regs.lcr <= LCR_RESET;
        end else begin
            case (wr_tgt)
                T_LCR:  regs.lcr  <= wdata;
                T_DLL:  regs.dll  <= wdata;
                T_DLM:  regs.dlm  <= wdata;
                T_DLD:  regs.dld  <= wdata;
                T_IER:  regs.ier  <= (wdata & ier_keep) | (regs.ier & ~ier_keep);
                T_MCR:  regs.mcr  <= (wdata & mcr_keep) | (regs.mcr & ~mcr_keep);
                T_EFR:  regs.efr  <= wdata;
                T_FCTR: regs.fctr <= wdata;
                T_EMSR: regs.emsr <= wdata;
                T_SPR:  regs.spr  <= wdata;
                T_MODE: regs.mode <= wdata[DW-1 -: MODE_W];
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < FLOW_N; g++) begin : g_flow
        tgt_e my_tgt;
        assign my_tgt = tgt_e'(T_XON1 + g);
        always_ff @(posedge clk) begin
            if (rst)
                flow_q[g] <= '0;
            else if (wr_tgt == my_tgt)
                flow_q[g] <= wdata;
        end
        assign flow[g*DW +: DW] = flow_q[g];
    end
endmodule

// File: rtl/rb_rdmux.sv
module rb_rdmux
    import uart_rb_pkg::*;
(
    input  tgt_e                  rd_tgt,
    input  regs_t                 regs,
    input  logic [FLOW_N*DW-1:0]  flow,
    input  logic [DW-1:0]         rx_data,
    input  logic [DW-1:0]         fifo_level,
    input  logic [DW-1:0]         isr,
    input  logic [DW-1:0]         lsr,
    input  logic [DW-1:0]         msr,
    output logic [DW-1:0]         ier_eff,
    output logic [DW-1:0]         mcr_eff,
    output logic [DW-1:0]         rdata
);
    logic gate;
    assign gate    = regs.efr[GATE_BIT];
    assign ier_eff = regs.ier & gated_mask(gate, IER_BASE_MASK);
    assign mcr_eff = regs.mcr & gated_mask(gate, MCR_BASE_MASK);

    always_comb begin
        case (rd_tgt)
            T_RHR:   rdata = rx_data;
            T_IER:   rdata = ier_eff;
            T_DLL:   rdata = regs.dll;
            T_DLM:   rdata = regs.dlm;
            T_DLD:   rdata = regs.dld;
            T_ISR:   rdata = isr;
            T_LCR:   rdata = regs.lcr;
            T_MCR:   rdata = mcr_eff;
            T_LSR:   rdata = lsr;
            T_MSR:   rdata = msr;
            T_SPR:   rdata = regs.spr;
            T_FC:    rdata = fifo_level;
            T_FCTR:  rdata = regs.fctr;
            T_EFR:   rdata = regs.efr;
            T_XON1:  rdata = flow[0*DW +: DW];
            T_XON2:  rdata = flow[1*DW +: DW];
            T_XOFF1: rdata = flow[2*DW +: DW];
            T_XOFF2: rdata = flow[3*DW +: DW];
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/rb_strobe.sv
module rb_strobe
    import uart_rb_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  tgt_e           rd_tgt,
    input  tgt_e           wr_tgt,
    input  logic [DW-1:0]  wdata,
    output strobe_t        stb,
    output logic [DW-1:0]  stb_data
);
    strobe_t nxt;

    always_comb begin
        nxt         = '0;
        nxt.rx_pop  = (rd_tgt == T_RHR);
        nxt.isr_rd  = (rd_tgt == T_ISR);
        nxt.lsr_rd  = (rd_tgt == T_LSR);
        nxt.msr_rd  = (rd_tgt == T_MSR);
        nxt.tx_push = (wr_tgt == T_THR);
        nxt.fcr_wr  = (wr_tgt == T_FCR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stb      <= '0;
            stb_data <= '0;
        end else begin
            stb <= nxt;
            if (nxt.tx_push || nxt.fcr_wr)
                stb_data <= wdata;
        end
    end
endmodule

// File: rtl/uart_regbank_decoder.sv
module uart_regbank_decoder
    import uart_rb_pkg::*;
#(
    parameter logic [7:0] ENH_KEY   = 8'hBF,
    parameter logic [7:0] LCR_RESET = 8'h03
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_i,
    input  logic        rd_i,
    input  logic        wr_i,
    input  logic [2:0]  addr_i,
    input  logic [7:0]  wdata_i,
    output logic [7:0]  rdata_o,
    input  logic [7:0]  rx_data_i,
    input  logic [7:0]  fifo_level_i,
    input  logic [7:0]  isr_i,
    input  logic [7:0]  lsr_i,
    input  logic [7:0]  msr_i,
    output logic        rx_pop_o,
    output logic        tx_push_o,
    output logic        fcr_wr_o,
    output logic        isr_rd_o,
    output logic        lsr_rd_o,
    output logic        msr_rd_o,
    output logic [7:0]  strobe_data_o,
    output logic [7:0]  lcr_o,
    output logic [7:0]  dll_o,
    output logic [7:0]  dlm_o,
    output logic [7:0]  dld_o,
    output logic [7:0]  ier_o,
    output logic [7:0]  mcr_o,
    output logic [7:0]  efr_o,
    output logic [7:0]  fctr_o,
    output logic [7:0]  emsr_o,
    output logic [3:0]  mode_o,
    output logic [31:0] flow_chars_o
);
    regs_t   regs;
    strobe_t stb;
    tgt_e    rd_tgt;
    tgt_e    wr_tgt;
    logic    rd_en;
    logic    wr_en;
    logic [FLOW_N*DW-1:0] flow;

    rb_decode #(.ENH_KEY(ENH_KEY)) u_decode (
        .cs(cs_i), .rd(rd_i), .wr(wr_i), .addr(addr_i),
        .lcr(regs.lcr), .gate(regs.efr[GATE_BIT]), .alias_on(regs.fctr[ALIAS_BIT]),
        .rd_en(rd_en), .wr_en(wr_en), .rd_tgt(rd_tgt), .wr_tgt(wr_tgt)
    );

    rb_regs #(.LCR_RESET(LCR_RESET)) u_regs (
        .clk(clk), .rst(rst), .wr_tgt(wr_tgt), .wdata(wdata_i),
        .regs(regs), .flow(flow)
    );

    rb_rdmux u_rdmux (
        .rd_tgt(rd_tgt), .regs(regs), .flow(flow),
        .rx_data(rx_data_i), .fifo_level(fifo_level_i),
        .isr(isr_i), .lsr(lsr_i), .msr(msr_i),
        .ier_eff(ier_o), .mcr_eff(mcr_o), .rdata(rdata_o)
    );

    rb_strobe u_strobe (
        .clk(clk), .rst(rst), .rd_tgt(rd_tgt), .wr_tgt(wr_tgt),
        .wdata(wdata_i), .stb(stb), .stb_data(strobe_data_o)
    );

    assign rx_pop_o     = stb.rx_pop;
    assign tx_push_o    = stb.tx_push;
    assign fcr_wr_o     = stb.fcr_wr;
    assign isr_rd_o     = stb.isr_rd;
    assign lsr_rd_o     = stb.lsr_rd;
    assign msr_rd_o     = stb.msr_rd;
    assign lcr_o        = regs.lcr;
    assign dll_o        = regs.dll;
    assign dlm_o        = regs.dlm;
    assign dld_o        = regs.dld;
    assign efr_o        = regs.efr;
    assign fctr_o       = regs.fctr;
    assign emsr_o       = regs.emsr;
    assign mode_o       = regs.mode;
    assign flow_chars_o = flow;
endmodule

// File: rtl/uart_regbank_checker.sv
module uart_regbank_checker (
    input logic       clk,
    input logic       rst,
    input logic       cs_i,
    input logic       rd_i,
    input logic       wr_i,
    input logic [2:0] addr_i,
    input logic [7:0] wdata_i,
    input logic       rx_pop_o,
    input logic       tx_push_o,
    input logic       fcr_wr_o,
    input logic       isr_rd_o,
    input logic       lsr_rd_o,
    input logic       msr_rd_o,
    input logic [7:0] lcr_o,
    input logic [7:0] dll_o,
    input logic [7:0] efr_o
);
    assert_pop_source_R1: assert property (@(posedge clk) disable iff (rst)
        rx_pop_o |-> $past(cs_i && rd_i && !wr_i && addr_i == 3'd0 && !lcr_o[7]));

    assert_push_source_R1: assert property (@(posedge clk) disable iff (rst)
        tx_push_o |-> $past(cs_i && wr_i && addr_i == 3'd0 && !lcr_o[7]));

    assert_div_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !(cs_i && wr_i && addr_i == 3'd0 && lcr_o[7] && lcr_o != 8'hBF) |=> $stable(dll_o));

    assert_efr_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !(cs_i && wr_i && addr_i == 3'd2 && lcr_o == 8'hBF) |=> $stable(efr_o));

    assert_lcr_write_R8: assert property (@(posedge clk) disable iff (rst)
        (cs_i && wr_i && addr_i == 3'd3) |=> (lcr_o == $past(wdata_i)));

    assert_one_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rx_pop_o, tx_push_o, fcr_wr_o, isr_rd_o, lsr_rd_o, msr_rd_o}));

    assert_reset_values_R10: assert property (@(posedge clk)
        rst |=> (lcr_o == 8'h03 && efr_o == 8'h00 && dll_o == 8'h00 && !rx_pop_o && !tx_push_o));

    assert_rw_overlap_R12: assert property (@(posedge clk) disable iff (rst)
        (cs_i && rd_i && wr_i) |=> !(rx_pop_o || isr_rd_o || lsr_rd_o || msr_rd_o));
endmodule

bind uart_regbank_decoder uart_regbank_checker u_checker (
    .clk(clk), .rst(rst), .cs_i(cs_i), .rd_i(rd_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i),
    .rx_pop_o(rx_pop_o), .tx_push_o(tx_push_o), .fcr_wr_o(fcr_wr_o),
    .isr_rd_o(isr_rd_o), .lsr_rd_o(lsr_rd_o), .msr_rd_o(msr_rd_o),
    .lcr_o(lcr_o), .dll_o(dll_o), .efr_o(efr_o)
);

// File: tb/uart_regbank_decoder_bench.sv
module uart_regbank_decoder_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
    logic [2:0]  addr_i = '0;
    logic [7:0]  wdata_i = '0;
    logic [7:0]  rdata_o;
    logic [7:0]  rx_data_i = 8'h5A, fifo_level_i = 8'h0C, isr_i = 8'hC1;
    logic [7:0]  lsr_i = 8'h61, msr_i = 8'hB0;
    logic        rx_pop_o, tx_push_o, fcr_wr_o, isr_rd_o, lsr_rd_o, msr_rd_o;
    logic [7:0]  strobe_data_o, lcr_o, dll_o, dlm_o, dld_o, ier_o, mcr_o;
    logic [7:0]  efr_o, fctr_o, emsr_o;
    logic [3:0]  mode_o;
    logic [31:0] flow_chars_o;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_lcr, m_dll, m_dlm, m_dld, m_ier, m_mcr, m_efr, m_fctr, m_emsr, m_spr;
    logic [7:0] m_flow [4];
    logic [3:0] m_mode;

    always #10 clk = ~clk;

    uart_regbank_decoder u_uart_regbank_decoder (
        .clk(clk), .rst(rst), .cs_i(cs_i), .rd_i(rd_i), .wr_i(wr_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .rx_data_i(rx_data_i), .fifo_level_i(fifo_level_i), .isr_i(isr_i),
        .lsr_i(lsr_i), .msr_i(msr_i),
        .rx_pop_o(rx_pop_o), .tx_push_o(tx_push_o), .fcr_wr_o(fcr_wr_o),
        .isr_rd_o(isr_rd_o), .lsr_rd_o(lsr_rd_o), .msr_rd_o(msr_rd_o),
        .strobe_data_o(strobe_data_o), .lcr_o(lcr_o), .dll_o(dll_o),
        .dlm_o(dlm_o), .dld_o(dld_o), .ier_o(ier_o), .mcr_o(mcr_o),
        .efr_o(efr_o), .fctr_o(fctr_o), .emsr_o(emsr_o), .mode_o(mode_o),
        .flow_chars_o(flow_chars_o)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic enh();  return m_lcr == 8'hBF; endfunction
    function automatic logic dvb();  return m_lcr[7] && !enh(); endfunction
    function automatic logic gate(); return m_efr[4]; endfunction

    function automatic string tag_of(input logic [2:0] a);
        if (enh() && a != 3'd3) return "R4";
        case (a)
            3'd0, 3'd1: return dvb() ? "R2" : "R1";
            3'd2: return "R3";
            3'd3: return "R8";
            3'd4: return "R7";
            3'd5: return "R8";
            3'd6: return "R6";
            default: return "R5";
        endcase
    endfunction

    function automatic logic [7:0] ier_eff(); return gate() ? m_ier : (m_ier & 8'h0F); endfunction
    function automatic logic [7:0] mcr_eff(); return gate() ? m_mcr : (m_mcr & 8'h1F); endfunction

    // strobe order {rx_pop, tx_push, fcr_wr, isr_rd, lsr_rd, msr_rd}
    function automatic logic [5:0] exp_rd_stb(input logic [2:0] a);
        if (enh()) return 6'b0;
        if (a == 3'd0 && !dvb()) return 6'b100000;
        if (a == 3'd2 && !(dvb() && gate())) return 6'b000100;
        if (a == 3'd5) return 6'b000010;
        if (a == 3'd6) return 6'b000001;
        return 6'b0;
    endfunction

    function automatic logic [5:0] exp_wr_stb(input logic [2:0] a);
        if (enh()) return 6'b0;
        if (a == 3'd0 && !dvb()) return 6'b010000;
        if (a == 3'd2 && !(dvb() && gate())) return 6'b001000;
        return 6'b0;
    endfunction

    function automatic logic [7:0] exp_read(input logic [2:0] a);
        if (enh()) begin
            case (a)
                3'd0: return fifo_level_i;
                3'd1: return m_fctr;
                3'd2: return m_efr;
                3'd3: return m_lcr;
                default: return m_flow[a - 3'd4];
            endcase
        end
        case (a)
            3'd0: return dvb() ? m_dll : rx_data_i;
            3'd1: return dvb() ? m_dlm : ier_eff();
            3'd2: return (dvb() && gate()) ? m_dld : isr_i;
            3'd3: return m_lcr;
            3'd4: return mcr_eff();
            3'd5: return lsr_i;
            3'd6: return msr_i;
            default: return m_fctr[6] ? fifo_level_i : m_spr;
        endcase
    endfunction

    task automatic model_write(input logic [2:0] a, input logic [7:0] d);
        if (a == 3'd3) begin m_lcr = d; return; end
        if (enh()) begin
            case (a)
                3'd1: m_fctr = d;
                3'd2: m_efr = d;
                3'd4, 3'd5, 3'd6, 3'd7: m_flow[a - 3'd4] = d;
                default: ;
            endcase
            return;
        end
        case (a)
            3'd0: if (dvb()) m_dll = d;
            3'd1: if (dvb()) m_dlm = d;
                  else m_ier = gate() ? d : {m_ier[7:4], d[3:0]};
            3'd2: if (dvb() && gate()) m_dld = d;
            3'd4: m_mcr = gate() ? d : {m_mcr[7:5], d[4:0]};
            3'd6: if (gate()) m_mode = d[7:4];
            3'd7: if (m_fctr[6]) m_emsr = d; else m_spr = d;
            default: ;
        endcase
    endtask

    function automatic logic [5:0] dut_stb();
        return {rx_pop_o, tx_push_o, fcr_wr_o, isr_rd_o, lsr_rd_o, msr_rd_o};
    endfunction

    function automatic logic [63:0] dut_regs_a();
        return {lcr_o, dll_o, dlm_o, dld_o, ier_o, mcr_o, efr_o, fctr_o};
    endfunction
    function automatic logic [63:0] model_regs_a();
        return {m_lcr, m_dll, m_dlm, m_dld, ier_eff(), mcr_eff(), m_efr, m_fctr};
    endfunction
    function automatic logic [63:0] dut_regs_b();
        return {20'b0, emsr_o, mode_o, flow_chars_o};
    endfunction
    function automatic logic [63:0] model_regs_b();
        return {20'b0, m_emsr, m_mode, m_flow[3], m_flow[2], m_flow[1], m_flow[0]};
    endfunction

    task automatic do_write(input logic [2:0] a, input logic [7:0] d);
        logic [5:0]  es;
        logic [63:0] before_a, before_b;
        string tg;
        es = exp_wr_stb(a);
        before_a = model_regs_a();
        before_b = model_regs_b();
        tg = tag_of(a);
        @(negedge clk);
        cs_i = 1'b1; wr_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        cs_i = 1'b0; wr_i = 1'b0;
        model_write(a, d);
        if (es == 6'b0 && model_regs_a() == before_a && model_regs_b() == before_b)
            tg = "R11";
        check("R9 write strobe", {58'b0, dut_stb()}, {58'b0, es});
        if (es != 6'b0) check("R9 strobe data", {56'b0, strobe_data_o}, {56'b0, d});
        check(tg, dut_regs_a(), model_regs_a());
        check(tg, dut_regs_b(), model_regs_b());
    endtask

    task automatic do_read(input logic [2:0] a);
        logic [5:0] es;
        es = exp_rd_stb(a);
        @(negedge clk);
        cs_i = 1'b1; rd_i = 1'b1; addr_i = a;
        #1;
        check(tag_of(a), {56'b0, rdata_o}, {56'b0, exp_read(a)});
        @(negedge clk);
        cs_i = 1'b0; rd_i = 1'b0;
        check("R9 read strobe", {58'b0, dut_stb()}, {58'b0, es});
        @(negedge clk);
        check("R9 strobe width", {58'b0, dut_stb()}, 64'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] lsel [3];
        lsel[0] = 8'h03; lsel[1] = 8'h83; lsel[2] = 8'hBF;
        m_lcr = 8'h03; m_dll = 0; m_dlm = 0; m_dld = 0; m_ier = 0; m_mcr = 0;
        m_efr = 0; m_fctr = 0; m_emsr = 0; m_spr = 0; m_mode = 0;
        for (int i = 0; i < 4; i++) m_flow[i] = 8'h00;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 reset regs", dut_regs_a(), model_regs_a());
        check("R10 reset regs", dut_regs_b(), model_regs_b());
        check("R10 reset strobes", {58'b0, dut_stb()}, 64'b0);
        do_read(3'd3);

        // overlap of read and write on index 0 in the standard bank
        @(negedge clk);
        cs_i = 1'b1; rd_i = 1'b1; wr_i = 1'b1; addr_i = 3'd0; wdata_i = 8'h3C;
        @(negedge clk);
        cs_i = 1'b0; rd_i = 1'b0; wr_i = 1'b0;
        check("R12 overlap strobes", {58'b0, dut_stb()}, {58'b0, 6'b010000});
        check("R12 overlap data", {56'b0, strobe_data_o}, 64'h3C);

        for (int l = 0; l < 3; l++) begin
            for (int e = 0; e < 2; e++) begin
                for (int f = 0; f < 2; f++) begin
                    do_write(3'd3, 8'hBF);
                    do_write(3'd2, {3'b0, e[0], 4'b0});
                    do_write(3'd1, {1'b0, f[0], 6'b0});
                    do_write(3'd3, lsel[l]);
                    for (int a = 0; a < 8; a++) begin
                        if (a == 3) continue;
                        rx_data_i    = 8'h20 + 8'(a * 3 + l);
                        fifo_level_i = 8'h40 + 8'(a + e * 8);
                        isr_i        = 8'hC0 ^ 8'(a + f);
                        lsr_i        = 8'h60 + 8'(l);
                        msr_i        = 8'hB0 + 8'(e + f);
                        do_write(3'(a), 8'hC3 ^ 8'(a * 29) ^ {3'b0, l[1:0], e[0], f[0], 1'b0});
                        do_read(3'(a));
                    end
                    do_read(3'd3);
                end
            end
        end

        // gate lowered after upper bits were set: R7 hold and mask
        do_write(3'd3, 8'hBF);
        do_write(3'd2, 8'h10);
        do_write(3'd3, 8'h03);
        do_write(3'd1, 8'hF5);
        do_write(3'd4, 8'hE9);
        do_write(3'd3, 8'hBF);
        do_write(3'd2, 8'h00);
        do_write(3'd3, 8'h03);
        do_read(3'd1);
        do_write(3'd1, 8'h0A);
        do_write(3'd4, 8'h02);
        do_write(3'd3, 8'hBF);
        do_write(3'd2, 8'h10);
        do_write(3'd3, 8'h03);
        check("R7 upper bits kept", {48'b0, ier_o, mcr_o}, {48'b0, 8'hFA, 8'hE2});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule